// File: doc/BRIEF.md
# CPU Reset and Turbo Control Register

This block is a one-byte control register on the I/O space. Software writes it to set deturbo mode and to ask for a CPU reset of one of three kinds: a hard reset, a soft reset, or a hard reset followed by a built-in self-test. The block decodes byte reads and writes to its port and holds four control bits. The upper four bits read as zero. A deturbo output follows the enable bit, and the clock throttling itself happens elsewhere.

A reset is requested by moving the trigger bit from 0 to 1. The block compares the written value against the value it already holds, and it takes the reset kind from the select bits written in that same access. A sequencer then drives the active-low RESET# and INIT# lines for a fixed number of clocks. A busy output is high for the whole sequence, and trigger edges that arrive while it is high are dropped. In the self-test kind, INIT# stays low for an extra hold interval after RESET# has gone high again.

Top module: `cpu_rst_ctl`

## Requirements
- R1: After the system reset input is asserted, the register reads 00h, cpu_reset_n and cpu_init_n are high, and busy and deturbo are low.
- R2: A write with io_addr equal to PORT_ADDR (default 0CF9h) stores io_wdata[3:0]. A read at that address returns {4'b0000, stored bits} on io_rdata in the same cycle. Reads at any other address return 00h, and writes at any other address leave the register unchanged.
- R3: deturbo equals stored bit 0 (1 = deturbo on), starting on the clock after the write.
- R4: A sequence starts only when a write sets bit 2 to 1 while the stored bit 2 is 0. Writing bit 2 = 1 when it already holds 1 starts nothing.
- R5: A trigger write is ignored while the stored bit 0 (deturbo) is 1.
- R6: Hard reset (bit 3 = 0, bit 1 = 1) drives cpu_reset_n low for HARD_CYCLES clocks (default 16) and keeps cpu_init_n high.
- R7: Soft reset (bit 3 = 0, bit 1 = 0) drives cpu_init_n low for SOFT_CYCLES clocks (default 4) and keeps cpu_reset_n high.
- R8: Reset with self-test (bit 3 = 1, whatever bit 1 holds) drives both lines low for HARD_CYCLES clocks. cpu_reset_n then goes high, and cpu_init_n stays low for BIST_HOLD further clocks (default 8).
- R9: busy rises on the clock after the trigger write. The reset lines go low one clock later. busy stays high until both lines are high again, and trigger edges written while busy is high start no sequence.
- R10: The reset kind is taken from bits 3:1 of the trigger write. Later writes to those bits during a sequence do not change the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, zero when the port is not selected |
| cpu_reset_n | output | 1 | CPU hard reset, active low |
| cpu_init_n | output | 1 | CPU init, active low |
| deturbo | output | 1 | Deturbo mode request level |
| busy | output | 1 | High while a reset sequence is pending or running |

## Verification
A sequencer in the wrong state appears at the pins within one clock as a reset line that is low while busy is low, or as a pulse whose length or order differs from the length and order of the selected kind. A missed or extra edge detection shows as busy rising when it should not, or failing to rise, on the clock after the write. A wrongly latched kind shows in the count of low clocks on each line, and that count is known once busy falls.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
  typedef enum logic [1:0] {
    RK_SOFT = 2'd0,
    RK_HARD = 2'd1,
    RK_BIST = 2'd2
  } rst_kind_t;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_HARD  = 3'd1,
    SQ_SOFT  = 3'd2,
    SQ_BRST  = 3'd3,
    SQ_BHOLD = 3'd4
  } seq_state_t;

  localparam int CTL_W = 4;
  localparam int BIT_DETURBO = 0;
  localparam int BIT_HARD    = 1;
  localparam int BIT_TRIG    = 2;
  localparam int BIT_BIST    = 3;
endpackage

// File: rtl/cpu_rst_regs.sv
module cpu_rst_regs
  import cpu_rst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              seq_busy,
  output logic              start,
  output rst_kind_t         kind,
  output logic              deturbo
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             start_q, start_d;
  rst_kind_t        kind_q, kind_d;
  logic             sel, wr_hit, fire;

  assign sel    = (io_addr == PORT_ADDR);
  assign wr_hit = io_wr && sel;
  assign fire   = wr_hit && io_wdata[BIT_TRIG] && !ctl_q[BIT_TRIG]
                  && !ctl_q[BIT_DETURBO] && !seq_busy && !start_q;

  always_comb begin
    ctl_d   = ctl_q;
    kind_d  = kind_q;
    start_d = fire;
    if (wr_hit) ctl_d = io_wdata[CTL_W-1:0];
    if (fire) begin
      if (io_wdata[BIT_BIST])      kind_d = RK_BIST;
      else if (io_wdata[BIT_HARD]) kind_d = RK_HARD;
      else                         kind_d = RK_SOFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      start_q <= 1'b0;
      kind_q  <= RK_SOFT;
    end else begin
      start_q <= start_d;
      if (wr_hit) ctl_q  <= ctl_d;
      if (fire)   kind_q <= kind_d;
    end
  end

  assign io_rdata = (io_rd && sel) ? {{(8-CTL_W){1'b0}}, ctl_q} : 8'h00;
  assign start    = start_q;
  assign kind     = kind_q;
  assign deturbo  = ctl_q[BIT_DETURBO];
endmodule

// File: rtl/cpu_rst_seq.sv
module cpu_rst_seq
  import cpu_rst_pkg::*;
#(
  parameter int HARD_CYCLES = 16,
  parameter int SOFT_CYCLES = 4,
  parameter int BIST_HOLD   = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  rst_kind_t kind,
  output logic      active,
  output logic      cpu_reset_n,
  output logic      cpu_init_n
);
  localparam int MAX_A = (HARD_CYCLES > SOFT_CYCLES) ? HARD_CYCLES : SOFT_CYCLES;
  localparam int MAX_C = (MAX_A > BIST_HOLD) ? MAX_A : BIST_HOLD;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] LD_HARD = CNT_W'(HARD_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_SOFT = CNT_W'(SOFT_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_BIST = CNT_W'(BIST_HOLD - 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          cnt_en = 1'b1;
          unique case (kind)
            RK_HARD: begin st_d = SQ_HARD; cnt_d = LD_HARD; end
            RK_BIST: begin st_d = SQ_BRST; cnt_d = LD_HARD; end
            default: begin st_d = SQ_SOFT; cnt_d = LD_SOFT; end
          endcase
        end
      end
      default: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          if (st_q == SQ_BRST) begin
            st_d  = SQ_BHOLD;
            cnt_d = LD_BIST;
          end else begin
            st_d = SQ_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign active      = (st_q != SQ_IDLE);
  assign cpu_reset_n = !((st_q == SQ_HARD) || (st_q == SQ_BRST));
  assign cpu_init_n  = !((st_q == SQ_SOFT) || (st_q == SQ_BRST) || (st_q == SQ_BHOLD));
endmodule

// File: rtl/cpu_rst_ctl.sv
module cpu_rst_ctl
  import cpu_rst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9,
  parameter int HARD_CYCLES = 16,
  parameter int SOFT_CYCLES = 4,
  parameter int BIST_HOLD   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cpu_reset_n,
  output logic              cpu_init_n,
  output logic              deturbo,
  output logic              busy
);
  logic      start, active;
  rst_kind_t kind;

  cpu_rst_regs #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .seq_busy(active), .start(start), .kind(kind), .deturbo(deturbo)
  );

  cpu_rst_seq #(.HARD_CYCLES(HARD_CYCLES), .SOFT_CYCLES(SOFT_CYCLES),
                .BIST_HOLD(BIST_HOLD)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .active(active),
    .cpu_reset_n(cpu_reset_n), .cpu_init_n(cpu_init_n)
  );

  assign busy = active || start;
endmodule

// File: rtl/cpu_rst_ctl_chk.sv
module cpu_rst_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cpu_reset_n,
  input logic              cpu_init_n,
  input logic              deturbo,
  input logic              busy
);
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata[7:4] == 4'h0);

  assert_deturbo_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORT_ADDR) |=> deturbo == $past(io_wdata[0]));

  assert_deturbo_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == PORT_ADDR && deturbo && !busy) |=> !busy);

  assert_idle_lines_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cpu_reset_n && cpu_init_n));

  assert_busy_then_assert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (!cpu_reset_n || !cpu_init_n));

  assert_reset_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_reset_n) |-> $past(busy));

  assert_init_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_init_n) |-> $past(busy));

  assert_bist_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_init_n) && busy) |-> cpu_reset_n);
endmodule

bind cpu_rst_ctl cpu_rst_ctl_chk #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_reset_n(cpu_reset_n),
  .cpu_init_n(cpu_init_n), .deturbo(deturbo), .busy(busy)
);

// File: tb/cpu_rst_ctl_test.sv
module cpu_rst_ctl_test;
  localparam int HC = 16, SC = 4, BH = 8;
  localparam logic [15:0] PORT = 16'h0CF9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic cpu_reset_n, cpu_init_n, deturbo, busy;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cpu_rst_ctl uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_reset_n(cpu_reset_n),
    .cpu_init_n(cpu_init_n), .deturbo(deturbo), .busy(busy)
  );

  // negedge monitor of low clocks on each line
  bit clr_mon = 0, busy_d = 0;
  int n_rst, n_init, n_only, n_seq;
  always @(negedge clk) begin
    if (clr_mon) begin
      n_rst = 0; n_init = 0; n_only = 0; n_seq = 0;
    end else begin
      if (!cpu_reset_n) n_rst++;
      if (!cpu_init_n) n_init++;
      if (!cpu_init_n && cpu_reset_n) n_only++;
      if (busy && !busy_d) n_seq++;
    end
    busy_d = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic clear_mon();
    @(negedge clk); clr_mon = 1; @(negedge clk); clr_mon = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int e_rst(bit trig, logic [7:0] v);
    if (!trig) return 0;
    return (v[3] || v[1]) ? HC : 0;
  endfunction
  function automatic int e_init(bit trig, logic [7:0] v);
    if (!trig) return 0;
    if (v[3]) return HC + BH;
    return v[1] ? 0 : SC;
  endfunction
  function automatic int e_only(bit trig, logic [7:0] v);
    if (!trig) return 0;
    if (v[3]) return BH;
    return v[1] ? 0 : SC;
  endfunction

  task automatic check_seq(input string tag, input bit trig, input logic [7:0] v);
    chk(n_seq == (trig ? 1 : 0), {tag, " seq count"}, n_seq, trig ? 1 : 0);
    chk(n_rst == e_rst(trig, v), {tag, " reset low"}, n_rst, e_rst(trig, v));
    chk(n_init == e_init(trig, v), {tag, " init low"}, n_init, e_init(trig, v));
    chk(n_only == e_only(trig, v), {tag, " init only"}, n_only, e_only(trig, v));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, pre, v;
    bit trig;
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cpu_reset_n && cpu_init_n, "R1 lines high", {cpu_reset_n, cpu_init_n}, 3);
    chk(!busy && !deturbo, "R1 busy/deturbo low", {busy, deturbo}, 0);
    rd(PORT, r);
    chk(r == 8'h00, "R1 reg reads 00h", r, 0);

    // R2 reserved bits and other addresses
    wr(PORT, 8'hF0);
    rd(PORT, r);
    chk(r == 8'h00, "R2 upper bits read zero", r, 0);
    wr(16'h0CF8, 8'h0B);
    rd(PORT, r);
    chk(r == 8'h00, "R2 other address write ignored", r, 0);
    wr(PORT, 8'h0A);
    rd(16'h0CFA, r);
    chk(r == 8'h00, "R2 other address reads zero", r, 0);
    rd(PORT, r);
    chk(r == 8'h0A, "R2 readback", r, 8'h0A);
    wr(PORT, 8'h00);

    // R6 R9 hard reset with busy/line timing
    clear_mon();
    @(negedge clk); io_addr = PORT; io_wdata = 8'h06; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
    chk(busy && cpu_reset_n, "R9 busy first, lines later", {busy, cpu_reset_n}, 3);
    @(negedge clk);
    chk(!cpu_reset_n && cpu_init_n, "R9 R6 reset low next clock", {cpu_reset_n, cpu_init_n}, 1);
    // R10: change kind bits mid-sequence, then R9 re-trigger attempt while busy
    repeat (2) @(negedge clk);
    wr(PORT, 8'h08);
    wr(PORT, 8'h04);
    wait_idle();
    check_seq("R6 R10 R9 hard", 1, 8'h06);

    // R4 rewrite of 1 while held 1
    clear_mon();
    wr(PORT, 8'h06);
    wait_idle();
    check_seq("R4 rewrite one", 0, 8'h06);

    // R7 soft
    wr(PORT, 8'h00);
    clear_mon();
    wr(PORT, 8'h04);
    wait_idle();
    check_seq("R7 soft", 1, 8'h04);

    // R8 bist with bit1 clear
    wr(PORT, 8'h00);
    clear_mon();
    wr(PORT, 8'h0C);
    wait_idle();
    check_seq("R8 bist", 1, 8'h0C);

    // R5 deturbo held
    wr(PORT, 8'h01);
    @(negedge clk);
    chk(deturbo == 1'b1, "R3 deturbo on", deturbo, 1);
    clear_mon();
    wr(PORT, 8'h06);
    wait_idle();
    check_seq("R5 deturbo blocks", 0, 8'h06);

    // random mix
    for (int i = 0; i < 24; i++) begin
      pre = 8'($urandom) & 8'hFB;
      v   = 8'($urandom) | 8'h04;
      wr(PORT, pre);
      rd(PORT, r);
      chk(r == (pre & 8'h0F), "R2 random readback", r, pre & 8'h0F);
      chk(deturbo == pre[0], "R3 random deturbo", deturbo, pre[0]);
      trig = !pre[0];
      clear_mon();
      wr(PORT, v);
      wait_idle();
      check_seq(trig ? "R4 R6 R7 R8 random" : "R5 random", trig, v);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule